// File: doc/BRIEF.md
# Runtime-Signed Multiply-Add Stage with Chain Input and Accumulator

This block forms several products in parallel and adds them into one two's complement sum. Each operand bus is a packed vector: slice i of A and slice i of B feed multiplier i. A control bit per bus selects at runtime whether every slice of that bus is read as signed or as unsigned. A value from a preceding stage of the same kind can enter on the chain input and is added to the products. The previous result can be fed back, so the block works as a multiply-accumulate. Rounding and saturation of the final sum are each switched on and off cycle by cycle, and a flag reports when saturation has clamped.

The block is a three-stage pipeline on one clock. An asynchronous clear empties every register and a clock enable freezes every register. Several of these blocks can be connected in series: the result of one drives the chain input of the next. A per-cycle control forces the result to zero, so a stage can be removed from such a chain without rewiring it.

Top module: `mac_chain_add`

## Requirements
- R1: With both sign controls low, the result is the sum over i of unsigned slice i of A times unsigned slice i of B. Slice i occupies bits [i*WIDTH_A +: WIDTH_A] of A and bits [i*WIDTH_B +: WIDTH_B] of B.
- R2: signA high makes every A slice two's complement, and signB high does the same for every B slice. Each control acts on its own bus, so all four combinations give distinct products.
- R3: chainIn is read as a WIDTH_CHAININ-bit two's complement number and is added into the sum.
- R4: When accumLoad or zeroLoop is high, the feedback term is zero and the result equals the new sum alone. When both are low, the previous result (sign-extended) is added to the new sum.
- R5: When zeroChain is high, the result is zero and overflow is low.
- R6: When roundEn is high, 1<<(ROUND_BITS-1) is added and the low ROUND_BITS bits are then cleared (round half up). When roundEn is low, the sum passes through unchanged.
- R7: When satEn is high, a sum above 2^(WIDTH_RESULT-1)-1 or below -2^(WIDTH_RESULT-1) is clamped to that limit and overflow goes high. When satEn is low, the result keeps the low WIDTH_RESULT bits of the sum and overflow stays low.
- R8: Result and overflow reflect the inputs presented three enabled rising clock edges earlier and not sooner.
- R9: While ena is low, no register changes, so result and overflow hold.
- R10: A high clr immediately forces result and overflow to zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Asynchronous clear, active high |
| ena | input | 1 | Clock enable for all registers |
| opA | input | NUM_MULT*WIDTH_A | Packed A operands |
| opB | input | NUM_MULT*WIDTH_B | Packed B operands |
| signA | input | 1 | 1: A slices are two's complement |
| signB | input | 1 | 1: B slices are two's complement |
| chainIn | input | WIDTH_CHAININ | Signed sum from a preceding stage |
| accumLoad | input | 1 | Start a new accumulation (no feedback) |
| zeroLoop | input | 1 | Force the feedback term to zero |
| zeroChain | input | 1 | Force the result to zero |
| roundEn | input | 1 | Enable round half up |
| satEn | input | 1 | Enable saturation |
| result | output | WIDTH_RESULT | Two's complement result |
| overflow | output | 1 | High when saturation clamped |

## Verification
Assertions check on every cycle that a forced-zero result is really zero, that overflow only appears after a cycle with saturation enabled and then only with the result at a limit, that a rounded unsaturated result has clear low bits, and that a disabled clock leaves the registers unchanged. The numeric value of a sum depends on the chosen signedness, the chain value, the feedback sequence and the rounding threshold. Only the bench's directed vectors show that these values are right, and they also show the exact three-edge latency and that the clear acts without a clock edge.

// File: rtl/mac_chain_pkg.sv
package mac_chain_pkg;

  // Per-cycle strobes from the control pipeline to the datapath.
  // signA/signB align with the stage-1 operand registers; the rest
  // align with the stage-2 product registers.
  typedef struct packed {
    logic signA;
    logic signB;
    logic doRound;
    logic doSat;
    logic clearFb;
    logic zeroOut;
  } macStrobe_t;

endpackage

// File: rtl/mac_chain_ctrl.sv
module mac_chain_ctrl
  import mac_chain_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       ena,
  input  logic       signA,
  input  logic       signB,
  input  logic       accumLoad,
  input  logic       zeroLoop,
  input  logic       zeroChain,
  input  logic       roundEn,
  input  logic       satEn,
  output macStrobe_t strobe
);

  macStrobe_t s1Q, s2Q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      s1Q <= '0;
      s2Q <= '0;
    end else if (ena) begin
      s1Q.signA   <= signA;
      s1Q.signB   <= signB;
      s1Q.doRound <= roundEn;
      s1Q.doSat   <= satEn;
      s1Q.clearFb <= accumLoad | zeroLoop;
      s1Q.zeroOut <= zeroChain;
      s2Q         <= s1Q;
    end
  end

  always_comb begin
    strobe         = s2Q;
    strobe.signA   = s1Q.signA;
    strobe.signB   = s1Q.signB;
  end

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (clr)
    !ena |=> $stable(strobe));

endmodule

// File: rtl/mac_chain_dp.sv
module mac_chain_dp
  import mac_chain_pkg::*;
#(
  parameter int NUM_MULT      = 2,
  parameter int WIDTH_A       = 8,
  parameter int WIDTH_B       = 8,
  parameter int WIDTH_CHAININ = 24,
  parameter int WIDTH_RESULT  = 24,
  parameter int ROUND_BITS    = 4
) (
  input  logic                          clk,
  input  logic                          clr,
  input  logic                          ena,
  input  logic [NUM_MULT*WIDTH_A-1:0]   opA,
  input  logic [NUM_MULT*WIDTH_B-1:0]   opB,
  input  logic [WIDTH_CHAININ-1:0]      chainIn,
  input  macStrobe_t                    strobe,
  output logic [WIDTH_RESULT-1:0]       result,
  output logic                          overflow
);

  localparam int PW    = WIDTH_A + WIDTH_B + 2;
  localparam int PSUM  = PW + $clog2(NUM_MULT) + 1;
  localparam int M1    = (PSUM > WIDTH_CHAININ) ? PSUM : WIDTH_CHAININ;
  localparam int M2    = (M1 > WIDTH_RESULT) ? M1 : WIDTH_RESULT;
  localparam int WIDE  = M2 + 3;
  localparam logic signed [WIDE-1:0] MAXV =
    {{(WIDE-WIDTH_RESULT+1){1'b0}}, {(WIDTH_RESULT-1){1'b1}}};
  localparam logic signed [WIDE-1:0] MINV = ~MAXV;
  localparam logic signed [WIDE-1:0] HALF =
    {{(WIDE-1){1'b0}}, 1'b1} << (ROUND_BITS-1);

  // stage 1: operand capture
  logic [NUM_MULT*WIDTH_A-1:0] aQ;
  logic [NUM_MULT*WIDTH_B-1:0] bQ;
  logic signed [WIDTH_CHAININ-1:0] chainQ1, chainQ2;
  // stage 2: products
  logic signed [WIDTH_A:0] aExt [NUM_MULT];
  logic signed [WIDTH_B:0] bExt [NUM_MULT];
  logic signed [PW-1:0] prodQ [NUM_MULT];
  // stage 3: sum / accumulator
  logic signed [WIDTH_RESULT-1:0] resultQ, nextRes;
  logic overflowQ, nextOvf;
  logic signed [WIDE-1:0] sumW, rndW;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      aQ      <= '0;
      bQ      <= '0;
      chainQ1 <= '0;
    end else if (ena) begin
      aQ      <= opA;
      bQ      <= opB;
      chainQ1 <= chainIn;
    end
  end

  // one extra bit per operand: sign or zero extension by runtime control
  for (genvar i = 0; i < NUM_MULT; i++) begin : g_ext
    assign aExt[i] = {strobe.signA & aQ[i*WIDTH_A+WIDTH_A-1], aQ[i*WIDTH_A +: WIDTH_A]};
    assign bExt[i] = {strobe.signB & bQ[i*WIDTH_B+WIDTH_B-1], bQ[i*WIDTH_B +: WIDTH_B]};
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      for (int i = 0; i < NUM_MULT; i++) prodQ[i] <= '0;
      chainQ2 <= '0;
    end else if (ena) begin
      for (int i = 0; i < NUM_MULT; i++) prodQ[i] <= PW'(aExt[i]) * PW'(bExt[i]);
      chainQ2 <= chainQ1;
    end
  end

  always_comb begin
    sumW = strobe.clearFb ? '0 : WIDE'(resultQ);
    sumW = sumW + WIDE'(chainQ2);
    for (int i = 0; i < NUM_MULT; i++) sumW = sumW + WIDE'(prodQ[i]);
    rndW = sumW;
    if (strobe.doRound) begin
      rndW = sumW + HALF;
      rndW[ROUND_BITS-1:0] = '0;
    end
    nextRes = rndW[WIDTH_RESULT-1:0];
    nextOvf = 1'b0;
    if (strobe.doSat) begin
      if (rndW > MAXV) begin
        nextRes = MAXV[WIDTH_RESULT-1:0];
        nextOvf = 1'b1;
      end else if (rndW < MINV) begin
        nextRes = MINV[WIDTH_RESULT-1:0];
        nextOvf = 1'b1;
      end
    end
    if (strobe.zeroOut) begin
      nextRes = '0;
      nextOvf = 1'b0;
    end
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      resultQ   <= '0;
      overflowQ <= 1'b0;
    end else if (ena) begin
      resultQ   <= nextRes;
      overflowQ <= nextOvf;
    end
  end

  assign result   = resultQ;
  assign overflow = overflowQ;

  assert_zero_chain_R5: assert property (@(posedge clk) disable iff (clr)
    (ena && strobe.zeroOut) |=> (result == '0 && !overflow));

  assert_ovf_needs_sat_R7: assert property (@(posedge clk) disable iff (clr)
    (ena && !strobe.doSat) |=> !overflow);

  assert_ovf_at_limit_R7: assert property (@(posedge clk) disable iff (clr)
    overflow |-> (result == MAXV[WIDTH_RESULT-1:0] || result == MINV[WIDTH_RESULT-1:0]));

  assert_round_aligned_R6: assert property (@(posedge clk) disable iff (clr)
    (ena && strobe.doRound && !strobe.doSat) |=> (result[ROUND_BITS-1:0] == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (clr)
    !ena |=> ($stable(result) && $stable(overflow)));

endmodule

// File: rtl/mac_chain_add.sv
module mac_chain_add
  import mac_chain_pkg::*;
#(
  parameter int NUM_MULT      = 2,
  parameter int WIDTH_A       = 8,
  parameter int WIDTH_B       = 8,
  parameter int WIDTH_CHAININ = 24,
  parameter int WIDTH_RESULT  = 24,
  parameter int ROUND_BITS    = 4
) (
  input  logic                        clk,
  input  logic                        clr,
  input  logic                        ena,
  input  logic [NUM_MULT*WIDTH_A-1:0] opA,
  input  logic [NUM_MULT*WIDTH_B-1:0] opB,
  input  logic                        signA,
  input  logic                        signB,
  input  logic [WIDTH_CHAININ-1:0]    chainIn,
  input  logic                        accumLoad,
  input  logic                        zeroLoop,
  input  logic                        zeroChain,
  input  logic                        roundEn,
  input  logic                        satEn,
  output logic [WIDTH_RESULT-1:0]     result,
  output logic                        overflow
);

  macStrobe_t strobe;

  mac_chain_ctrl ctrl_i (
    .clk(clk), .clr(clr), .ena(ena),
    .signA(signA), .signB(signB),
    .accumLoad(accumLoad), .zeroLoop(zeroLoop), .zeroChain(zeroChain),
    .roundEn(roundEn), .satEn(satEn),
    .strobe(strobe)
  );

  mac_chain_dp #(
    .NUM_MULT(NUM_MULT), .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B),
    .WIDTH_CHAININ(WIDTH_CHAININ), .WIDTH_RESULT(WIDTH_RESULT),
    .ROUND_BITS(ROUND_BITS)
  ) dp_i (
    .clk(clk), .clr(clr), .ena(ena),
    .opA(opA), .opB(opB), .chainIn(chainIn),
    .strobe(strobe),
    .result(result), .overflow(overflow)
  );

endmodule

// File: tb/mac_chain_add_tb_top.sv
`timescale 1ns/1ps
module mac_chain_add_tb_top;

  localparam int N   = 2;
  localparam int WA  = 8;
  localparam int WB  = 8;
  localparam int WCH = 24;
  localparam int WR  = 24;
  localparam int RB  = 4;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic ena = 1'b1;
  logic [N*WA-1:0] opA = '0;
  logic [N*WB-1:0] opB = '0;
  logic signA = 0, signB = 0;
  logic [WCH-1:0] chainIn = '0;
  logic accumLoad = 0, zeroLoop = 1, zeroChain = 0, roundEn = 0, satEn = 0;
  logic [WR-1:0] result;
  logic overflow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mac_chain_add #(.NUM_MULT(N), .WIDTH_A(WA), .WIDTH_B(WB),
    .WIDTH_CHAININ(WCH), .WIDTH_RESULT(WR), .ROUND_BITS(RB)) dut_i (
    .clk(clk), .clr(clr), .ena(ena), .opA(opA), .opB(opB),
    .signA(signA), .signB(signB), .chainIn(chainIn),
    .accumLoad(accumLoad), .zeroLoop(zeroLoop), .zeroChain(zeroChain),
    .roundEn(roundEn), .satEn(satEn), .result(result), .overflow(overflow));

  // reference model on the currently driven inputs, fb = previous result
  function automatic void model(input longint fb, output logic [WR-1:0] r, output bit o);
    longint sum, av, bv, c, f, maxv, minv;
    sum = 0;
    for (int i = 0; i < N; i++) begin
      av = longint'(opA[i*WA +: WA]);
      bv = longint'(opB[i*WB +: WB]);
      if (signA && av[WA-1]) av = av - (longint'(1) << WA);
      if (signB && bv[WB-1]) bv = bv - (longint'(1) << WB);
      sum = sum + av * bv;
    end
    c = longint'(chainIn);
    if (c[WCH-1]) c = c - (longint'(1) << WCH);
    f = (accumLoad || zeroLoop) ? 0 : fb;
    sum = sum + c + f;
    if (roundEn) sum = (sum + (longint'(1) << (RB-1))) & ~((longint'(1) << RB) - 1);
    maxv = (longint'(1) << (WR-1)) - 1;
    minv = -(longint'(1) << (WR-1));
    o = 0;
    r = sum[WR-1:0];
    if (satEn && sum > maxv) begin r = maxv[WR-1:0]; o = 1; end
    else if (satEn && sum < minv) begin r = minv[WR-1:0]; o = 1; end
    if (zeroChain) begin r = '0; o = 0; end
  endfunction

  function automatic longint sx(input logic [WR-1:0] v);
    longint t;
    t = longint'(v);
    if (v[WR-1]) t = t - (longint'(1) << WR);
    return t;
  endfunction

  task automatic check(input string req, input logic [WR-1:0] er, input bit eo);
    total++;
    if (result !== er || overflow !== eo) begin
      bad++;
      $display("FAIL %s: result=%h overflow=%b expected result=%h overflow=%b",
               req, result, overflow, er, eo);
    end
  endtask

  task automatic setVec(input logic [WA-1:0] a0, input logic [WB-1:0] b0,
                        input logic [WA-1:0] a1, input logic [WB-1:0] b1,
                        input logic sa, input logic sb, input logic [WCH-1:0] ch);
    opA = {a1, a0}; opB = {b1, b0};
    signA = sa; signB = sb; chainIn = ch;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic runCase(input string req);
    logic [WR-1:0] er; bit eo;
    model(0, er, eo);
    settle();
    check(req, er, eo);
  endtask

  task automatic testReset();
    clr = 1; @(negedge clk);
    check("R10 reset", '0, 0);
    clr = 0;
  endtask

  task automatic testUnsignedLatency();
    logic [WR-1:0] er; bit eo;
    setVec(8'd200, 8'd3, 8'd255, 8'd255, 0, 0, '0);
    model(0, er, eo);
    @(negedge clk); @(negedge clk);
    check("R8 not yet", '0, 0);
    @(negedge clk);
    check("R8 third edge", er, eo);
    check("R1 unsigned", 24'd65625, 0);
  endtask

  task automatic testSigned();
    setVec(8'hFD, 8'hFD, 8'h80, 8'h02, 1, 0, '0);
    runCase("R2 signA only");
    check("R2 signA value", 24'hFFFC09, 0);
    setVec(8'hFD, 8'hFD, 8'h80, 8'h02, 0, 1, '0);
    runCase("R2 signB only");
    setVec(8'hFD, 8'hFD, 8'h80, 8'h02, 1, 1, '0);
    runCase("R2 both signed");
  endtask

  task automatic testChain();
    setVec(8'd10, 8'd10, 8'd0, 8'd0, 0, 0, 24'hFFFC18);
    runCase("R3 chain negative");
    check("R3 chain value", 24'hFFFC7C, 0);
  endtask

  task automatic testRound();
    roundEn = 1;
    setVec(8'd23, 8'd1, 8'd0, 8'd0, 0, 0, '0);
    runCase("R6 round 23");
    check("R6 round 23 value", 24'd16, 0);
    setVec(8'd24, 8'd1, 8'd0, 8'd0, 0, 0, '0);
    runCase("R6 round half up");
    check("R6 round 24 value", 24'd32, 0);
    setVec(8'd7, 8'd1, 8'd0, 8'd0, 0, 0, '0);
    runCase("R6 round down");
    roundEn = 0;
    setVec(8'd23, 8'd1, 8'd0, 8'd0, 0, 0, '0);
    runCase("R6 bypass");
    check("R6 bypass value", 24'd23, 0);
  endtask

  task automatic testSat();
    satEn = 1;
    setVec(8'd255, 8'd255, 8'd0, 8'd0, 0, 0, 24'h7FFFFF);
    runCase("R7 clamp high");
    check("R7 clamp high value", 24'h7FFFFF, 1);
    setVec(8'h80, 8'd127, 8'd0, 8'd0, 1, 0, 24'h800000);
    runCase("R7 clamp low");
    check("R7 clamp low value", 24'h800000, 1);
    satEn = 0;
    setVec(8'd255, 8'd255, 8'd0, 8'd0, 0, 0, 24'h7FFFFF);
    runCase("R7 wrap");
    check("R7 wrap value", 24'h80FE00, 0);
  endtask

  task automatic testZero();
    satEn = 1; zeroChain = 1;
    setVec(8'd255, 8'd255, 8'd0, 8'd0, 0, 0, 24'h7FFFFF);
    runCase("R5 zero chain");
    check("R5 zero value", '0, 0);
    zeroChain = 0; satEn = 0;
  endtask

  task automatic testAccum();
    logic [WR-1:0] e1, e2, e3, e4; bit o;
    zeroLoop = 0; accumLoad = 1;
    setVec(8'd5, 8'd5, 8'd0, 8'd0, 0, 0, '0);
    model(0, e1, o);
    @(negedge clk);
    accumLoad = 0;
    setVec(8'd3, 8'd4, 8'd1, 8'd1, 0, 0, '0);
    model(sx(e1), e2, o);
    @(negedge clk);
    setVec(8'hFF, 8'd2, 8'd0, 8'd0, 1, 0, '0);
    model(sx(e2), e3, o);
    @(negedge clk);
    check("R4 load", e1, 0);
    zeroLoop = 1;
    setVec(8'd9, 8'd9, 8'd0, 8'd0, 0, 0, '0);
    model(sx(e3), e4, o);
    @(negedge clk);
    check("R4 add fb", e2, 0);
    check("R4 add fb value", 24'd38, 0);
    @(negedge clk);
    check("R4 add fb 2", e3, 0);
    @(negedge clk);
    check("R4 zero loop", e4, 0);
    check("R4 zero loop value", 24'd81, 0);
  endtask

  task automatic testEnable();
    logic [WR-1:0] er; bit eo;
    setVec(8'd12, 8'd12, 8'd0, 8'd0, 0, 0, '0);
    settle();
    ena = 0;
    setVec(8'd100, 8'd100, 8'd1, 8'd1, 0, 0, 24'd5);
    model(0, er, eo);
    repeat (5) @(negedge clk);
    check("R9 hold", 24'd144, 0);
    ena = 1;
    settle();
    check("R9 resume", er, eo);
  endtask

  task automatic testAsyncClear();
    setVec(8'd50, 8'd50, 8'd0, 8'd0, 0, 0, '0);
    settle();
    #2 clr = 1;
    #1 check("R10 async clear", '0, 0);
    @(negedge clk);
    clr = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: result=%h overflow=%b expected completion", result, overflow);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    testUnsignedLatency();
    testSigned();
    testChain();
    testRound();
    testSat();
    testZero();
    testAccum();
    testEnable();
    testAsyncClear();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule